// File: doc/BRIEF.md
# Effective Address Calculation Unit

This unit resolves the operand of one memory-reference instruction at a time. On a start pulse it takes in the address field, the number of the index register, the value that the register-file read port presents for that register, an indirection flag and a flag that chooses whether indexing happens before or after the pointer fetch. It then issues one or two single-cycle reads to a word-addressed data memory with one cycle of read latency. When it finishes it presents the final effective address and the operand fetched from that address, and it raises a done strobe.

Two operand kinds skip memory altogether. An immediate request returns the address field itself as the operand. A register-direct request returns the register read-port value. Addresses and memory words share one width (8 bits by default), and every address sum wraps modulo 2^8. Instruction decode, the register file and stores are handled elsewhere.

Top module: `eff_addr_unit`

## Requirements
- R1: After reset, busy, done and mem_rd_en are 0, and ea and operand are 0.
- R2: The op_kind encodings are 2'b00 and 2'b11 for a memory reference, 2'b01 for immediate and 2'b10 for register-direct. A memory reference with ind_en=0 and idx_reg=0 gives ea = addr_fld, makes exactly one read at ea, and returns operand = M[ea].
- R3: A memory reference with ind_en=0 and idx_reg nonzero gives ea = addr_fld + rf_data, with rf_data taken as a two's-complement value.
- R4: When idx_reg is 0, rf_data has no effect on the addresses in any memory-reference mode.
- R5: With ind_en=1 and post_idx=0 (pre-indexed), the pointer read goes to addr_fld + index and ea = M[addr_fld + index]. Example: addr 0x0A, index 7, M[0x11]=0x08 gives ea 0x08.
- R6: With ind_en=1 and post_idx=1 (post-indexed), the pointer read goes to addr_fld and ea = M[addr_fld] + index. Example: addr 0x0A, index 7, M[0x0A]=5 gives ea 0x0C.
- R7: Immediate gives operand = addr_fld, and register-direct gives operand = rf_data. In both, ea = 0 and no memory read is made.
- R8: Requests are accepted only when start is high and busy is 0. A start while busy is ignored. Inputs are sampled only in the accepting cycle. Busy is high from the accepting edge until done, and done is never high together with busy.
- R9: Reads per request: 0 for immediate and register-direct, 1 for direct and indexed, 2 for either indirect mode. Each read is a one-cycle mem_rd_en pulse.
- R10: Done is high in the cycle after the 1st clock edge that follows acceptance for bypass kinds, after the 3rd for non-indirect memory references, and after the 4th for indirect ones.
- R11: All address sums wrap modulo 256 (for example 0xF0 + 0x20 gives 0x10).
- R12: ea and operand hold their values from done until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe |
| op_kind | input | 2 | Operand kind: 00/11 memory, 01 immediate, 10 register-direct |
| addr_fld | input | 8 | Address field of the instruction |
| idx_reg | input | 3 | Index register number; 0 selects no indexing |
| rf_data | input | 8 | Register read-port value (the index, or the register-direct operand) |
| ind_en | input | 1 | 1 selects indirection |
| post_idx | input | 1 | With indirection: 0 indexes before the pointer fetch, 1 indexes after it |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid strobe |
| ea | output | 8 | Final effective address |
| operand | output | 8 | Fetched or bypassed operand |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 8 | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a request |

## Verification
The assertions assume that the memory returns data exactly one cycle after each mem_rd_en pulse. They also assume that start is held for a single cycle when a request is meant to be accepted. The bench keeps to both rules. Its memory model registers the word on the requesting edge, and its driver drops start at the falling edge right after acceptance. It raises start again during busy only to show that the unit ignores it. Random op_kind, index, field and flag values are drawn from a fixed seed. While a request runs, the bench scrambles the data inputs so that any late sampling shows up at the outputs.

// File: rtl/eau_pkg.sv
package eau_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PTR_RD  = 3'd1,
    ST_PTR_RSP = 3'd2,
    ST_OPR_RD  = 3'd3,
    ST_OPR_RSP = 3'd4,
    ST_DONE    = 3'd5
  } eau_state_e;

  typedef enum logic [1:0] {
    KIND_MEM     = 2'b00,
    KIND_IMM     = 2'b01,
    KIND_REG     = 2'b10,
    KIND_MEM_ALT = 2'b11
  } eau_kind_e;

  function automatic logic kind_bypass(input logic [1:0] k);
    return (k == KIND_IMM) || (k == KIND_REG);
  endfunction

endpackage

// File: rtl/eau_adder.sv
module eau_adder #(
  parameter int AW  = 8,
  parameter int RIW = 3
) (
  input  logic [AW-1:0]  base,
  input  logic [RIW-1:0] sel,
  input  logic [AW-1:0]  rf_val,
  output logic [AW-1:0]  idx_eff,
  output logic [AW-1:0]  sum
);
  // A register number of zero means no index; the sum wraps at 2^AW.
  always_comb begin
    idx_eff = (sel == '0) ? '0 : rf_val;
    sum     = base + idx_eff;
  end
endmodule

// File: rtl/eau_ctrl.sv
module eau_ctrl
  import eau_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] kind,
  input  logic       ind_en,
  output eau_state_e state,
  output logic       accept,
  output logic       busy,
  output logic       done,
  output logic       mem_rd_en
);
  eau_state_e state_q, state_d;

  always_comb begin
    accept = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          if (kind_bypass(kind)) state_d = ST_DONE;
          else if (ind_en)       state_d = ST_PTR_RD;
          else                   state_d = ST_OPR_RD;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_PTR_RD:  state_d = ST_PTR_RSP;
      ST_PTR_RSP: state_d = ST_OPR_RSP;
      ST_OPR_RD:  state_d = ST_OPR_RSP;
      ST_OPR_RSP: state_d = ST_DONE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state     = state_q;
    busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
    done      = (state_q == ST_DONE);
    mem_rd_en = (state_q == ST_PTR_RD) || (state_q == ST_PTR_RSP) ||
                (state_q == ST_OPR_RD);
  end

  // R7: bypass kinds finish on the next edge with no read
  p_bypass_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind_bypass(kind)) |=> (done && !mem_rd_en));

  // R10: direct/indexed: read, wait, done
  p_direct_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !kind_bypass(kind) && !ind_en) |=> mem_rd_en ##1 !mem_rd_en ##1 done);

  // R9: indirect: two back-to-back reads, then done
  p_indirect_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !kind_bypass(kind) && ind_en) |=>
      mem_rd_en ##1 mem_rd_en ##1 !mem_rd_en ##1 done);

endmodule

// File: rtl/eau_datapath.sv
module eau_datapath
  import eau_pkg::*;
#(
  parameter int AW  = 8,
  parameter int RIW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           start,
  input  logic           busy,
  input  eau_state_e     state,
  input  logic [1:0]     kind,
  input  logic [AW-1:0]  addr_fld,
  input  logic [RIW-1:0] idx_reg,
  input  logic [AW-1:0]  rf_data,
  input  logic           ind_en,
  input  logic           post_idx,
  input  logic [AW-1:0]  mem_rdata,
  output logic [AW-1:0]  ea,
  output logic [AW-1:0]  operand,
  output logic [AW-1:0]  mem_addr
);
  localparam logic [RIW-1:0] SEL_ALWAYS = '1;

  logic [AW-1:0] idx_q, ptr_q, ea_q, opr_q;
  logic          post_q;
  logic [AW-1:0] idx_d, ptr_d, ea_d, opr_d;
  logic          post_d;
  logic          req_en, ea_en, opr_en;
  logic [AW-1:0] idx_in, sum_in, idx_unused, post_sum, ea_ind;

  eau_adder #(.AW(AW), .RIW(RIW)) u_add_req (
    .base(addr_fld), .sel(idx_reg), .rf_val(rf_data),
    .idx_eff(idx_in), .sum(sum_in)
  );

  eau_adder #(.AW(AW), .RIW(RIW)) u_add_post (
    .base(mem_rdata), .sel(SEL_ALWAYS), .rf_val(idx_q),
    .idx_eff(idx_unused), .sum(post_sum)
  );

  always_comb begin
    ea_ind = post_q ? post_sum : mem_rdata;

    req_en = accept;
    ea_en  = accept || (state == ST_PTR_RSP);
    opr_en = accept || (state == ST_OPR_RSP);

    idx_d  = idx_in;
    post_d = post_idx;
    ptr_d  = post_idx ? addr_fld : sum_in;

    if (accept) begin
      if (kind_bypass(kind) || ind_en) ea_d = '0;
      else                             ea_d = sum_in;
    end else begin
      ea_d = ea_ind;
    end

    if (accept) begin
      if (kind == KIND_IMM)      opr_d = addr_fld;
      else if (kind == KIND_REG) opr_d = rf_data;
      else                       opr_d = '0;
    end else begin
      opr_d = mem_rdata;
    end

    case (state)
      ST_PTR_RD:  mem_addr = ptr_q;
      ST_PTR_RSP: mem_addr = ea_ind;
      default:    mem_addr = ea_q;
    endcase

    ea      = ea_q;
    operand = opr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ptr_q  <= '0;
      post_q <= 1'b0;
    end else if (req_en) begin
      idx_q  <= idx_d;
      ptr_q  <= ptr_d;
      post_q <= post_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ea_q <= '0;
    else if (ea_en) ea_q <= ea_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      opr_q <= '0;
    else if (opr_en) opr_q <= opr_d;
  end

  // R8: a start while busy leaves the captured request alone
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(ptr_q) && $stable(idx_q) && $stable(post_q)));

  // R2: the operand read went to the address now reported as ea
  p_opr_at_ea_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPR_RSP) |-> ($past(mem_addr) == ea_q));

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eau_pkg::*;
#(
  parameter int AW  = 8,
  parameter int RIW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     op_kind,
  input  logic [AW-1:0]  addr_fld,
  input  logic [RIW-1:0] idx_reg,
  input  logic [AW-1:0]  rf_data,
  input  logic           ind_en,
  input  logic           post_idx,
  output logic           busy,
  output logic           done,
  output logic [AW-1:0]  ea,
  output logic [AW-1:0]  operand,
  output logic           mem_rd_en,
  output logic [AW-1:0]  mem_addr,
  input  logic [AW-1:0]  mem_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       accept;
  eau_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  eau_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .kind(op_kind),
    .ind_en(ind_en), .state(state), .accept(accept), .busy(busy),
    .done(done), .mem_rd_en(mem_rd_en)
  );

  eau_datapath #(.AW(AW), .RIW(RIW)) u_dp (
    .clk(clk), .rst_n(rst_int_n), .accept(accept), .start(start),
    .busy(busy), .state(state), .kind(op_kind), .addr_fld(addr_fld),
    .idx_reg(idx_reg), .rf_data(rf_data), .ind_en(ind_en),
    .post_idx(post_idx), .mem_rdata(mem_rdata), .ea(ea),
    .operand(operand), .mem_addr(mem_addr)
  );

  // R12: results stay put after done when no new request arrives
  p_hold_outputs_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !start) |=> ($stable(ea) && $stable(operand)));

  // R8: done and busy are never high together
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !busy);

endmodule

// File: tb/eff_addr_unit_test.sv
`timescale 1ns/1ps
module eff_addr_unit_test;
  localparam int AW = 8;
  localparam int RIW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op_kind = '0;
  logic [AW-1:0] addr_fld = '0;
  logic [RIW-1:0] idx_reg = '0;
  logic [AW-1:0] rf_data = '0;
  logic ind_en = 1'b0, post_idx = 1'b0;
  logic busy, done, mem_rd_en;
  logic [AW-1:0] ea, operand, mem_addr;
  logic [AW-1:0] mem_rdata = '0;

  logic [AW-1:0] mem_m [256];
  int rcnt = 0;
  logic [AW-1:0] rlog [1024];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  eff_addr_unit #(.AW(AW), .RIW(RIW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
    .addr_fld(addr_fld), .idx_reg(idx_reg), .rf_data(rf_data),
    .ind_en(ind_en), .post_idx(post_idx), .busy(busy), .done(done),
    .ea(ea), .operand(operand), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem_m[mem_addr];
      rlog[rcnt % 1024] <= mem_addr;
      rcnt <= rcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] k, input logic [7:0] a,
                       input logic [2:0] s, input logic [7:0] rv,
                       input logic ind, input logic post,
                       output logic [7:0] e, output logic [7:0] o,
                       output int nr, output int lat,
                       output logic [7:0] a0, output logic [7:0] a1);
    logic [7:0] ix, pa;
    ix = (s == 0) ? 8'h00 : rv;
    a0 = 0; a1 = 0;
    if (k == 2'b01 || k == 2'b10) begin
      e = 0; o = (k == 2'b01) ? a : rv; nr = 0; lat = 1;
    end else if (!ind) begin
      e = a + ix; o = mem_m[e]; nr = 1; lat = 3; a0 = e;
    end else begin
      pa = post ? a : a + ix;
      e = post ? mem_m[pa] + ix : mem_m[pa];
      o = mem_m[e]; nr = 2; lat = 4; a0 = pa; a1 = e;
    end
  endtask

  task automatic do_op(input logic [1:0] k, input logic [7:0] a,
                       input logic [2:0] s, input logic [7:0] rv,
                       input logic ind, input logic post,
                       input string req, input bit intrude);
    logic [7:0] e, o, a0, a1;
    int nr, lat, base, n;
    bit busy_ok;
    model(k, a, s, rv, ind, post, e, o, nr, lat, a0, a1);
    @(negedge clk);
    op_kind = k; addr_fld = a; idx_reg = s; rf_data = rv;
    ind_en = ind; post_idx = post; start = 1'b1;
    base = rcnt;
    @(negedge clk);
    start = 1'b0;
    addr_fld = ~a; rf_data = rv ^ 8'h5A; idx_reg = ~s;
    ind_en = ~ind; post_idx = ~post; op_kind = ~k;
    n = 1;
    busy_ok = 1;
    while (!done && n < 20) begin
      if (!busy) busy_ok = 0;
      @(negedge clk);
      n++;
      if (intrude && n == 2) start = 1'b1;
      if (n == 3) start = 1'b0;
    end
    start = 1'b0;
    chk(n < 20, "R10", "timeout", n, lat);
    chk(n == lat, "R10", "latency", n, lat);
    chk(!busy && busy_ok, "R8", "busy shape", busy, 0);
    chk(ea == e, req, "ea", ea, e);
    chk(operand == o, req, "operand", operand, o);
    chk((rcnt - base) == nr, "R9", "read count", rcnt - base, nr);
    if (nr >= 1) chk(rlog[base % 1024] == a0, req, "first read addr", rlog[base % 1024], a0);
    if (nr == 2) chk(rlog[(base + 1) % 1024] == a1, req, "second read addr", rlog[(base + 1) % 1024], a1);
    repeat (3) @(negedge clk);
    chk(ea == e && operand == o, "R12", "hold", {ea, operand}, {e, o});
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 8'(i * 73 + 19);
    mem_m[8'h0A] = 8'h05;
    mem_m[8'h11] = 8'h08;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mem_rd_en, "R1", "reset ctrl", {busy, done, mem_rd_en}, 0);
    chk(ea == 0 && operand == 0, "R1", "reset data", {ea, operand}, 0);

    do_op(2'b00, 8'h20, 3'd0, 8'h33, 0, 0, "R2", 0);
    do_op(2'b11, 8'h41, 3'd0, 8'h00, 0, 0, "R2", 0);
    do_op(2'b00, 8'h0A, 3'd3, 8'h04, 0, 0, "R3", 0);
    do_op(2'b00, 8'h05, 3'd1, 8'hFE, 0, 0, "R3", 0);
    do_op(2'b00, 8'hF0, 3'd2, 8'h20, 0, 0, "R11", 0);
    do_op(2'b00, 8'h30, 3'd0, 8'h55, 0, 0, "R4", 0);
    do_op(2'b00, 8'h0A, 3'd0, 8'h55, 1, 1, "R4", 0);
    do_op(2'b00, 8'h0A, 3'd0, 8'h77, 1, 0, "R4", 0);
    do_op(2'b00, 8'h0A, 3'd5, 8'h07, 1, 0, "R5", 0);
    do_op(2'b00, 8'h0A, 3'd5, 8'h07, 1, 1, "R6", 0);
    do_op(2'b01, 8'h9C, 3'd2, 8'h11, 1, 0, "R7", 0);
    do_op(2'b10, 8'h9C, 3'd2, 8'hE1, 0, 1, "R7", 0);
    do_op(2'b00, 8'h12, 3'd4, 8'h03, 1, 1, "R8", 1);
    do_op(2'b00, 8'h12, 3'd4, 8'h03, 0, 0, "R8", 1);
    do_op(2'b00, 8'hFF, 3'd7, 8'h80, 1, 1, "R11", 0);

    for (int i = 0; i < 300; i++) begin
      logic [1:0] k;
      logic ind, post;
      k = 2'($urandom);
      ind = 1'($urandom);
      post = 1'($urandom);
      do_op(k, 8'($urandom), 3'($urandom), 8'($urandom), ind, post,
            (k == 2'b01 || k == 2'b10) ? "R7" : (ind ? (post ? "R6" : "R5") : "R3"),
            ($urandom % 8) == 0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule